// File: doc/BRIEF.md
# Recursive Half-Split Parallel Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. Each operand is cut into a low half and a high half. Four half-width multipliers form all four cross products at the same time, and each of them is built with the same split structure. The recursion ends at a 2-bit leaf, where the product comes straight from gates.

The two cross products are summed with one extra carry bit and moved up by N/2 positions. The shifted term is then cut at bit N. Its bottom N bits join the low-by-low product in a lower-word adder. Its top bits are zero-extended to N bits and join the high-by-high product in an upper-word adder, which also takes the carry out of the lower word. The product is the upper word placed above the lower word. All partial products are computed in one combinational pass. A parameter selects whether the result leaves through a reset register or straight from the logic.

Top module: `hsm_mul`

## Requirements
- R1: For every pair of N-bit unsigned operands, the output equals the exact 2N-bit product a_in × b_in.
- R2: When either operand is zero, all 2N output bits are zero.
- R3: With both operands all ones, the output equals (2^N − 1)², so its upper N bits are all ones except bit N, and its lower N bits are 1.
- R4: A carry out of the lower N-bit sum reaches the upper N bits. The case where the low product plus the lower slice of the shifted middle term exceeds 2^N − 1 gives the exact product.
- R5: Output bit 0 equals a_in[0] AND b_in[0].
- R6: With OUT_REG = 1, the product of operands present at a rising clock edge appears after that edge and holds until the next edge. While rst_n is low, the output is zero.
- R7: N must be a power of two of at least 2, and this is checked at elaboration. Widths 4, 8, 16 and 32 all build and give products 2N bits wide.
- R8: For N = 4, a_in = 4'b0011 and b_in = 4'b1001 give a lower word of 4'b1011, an upper word of 4'b0001, and a product of 8'b00011011.
- R9: When one operand is 1, the output equals the other operand zero-extended to 2N bits.
- R10: Exchanging the two operands does not change the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset that clears the output register |
| a_in | input | N | First unsigned operand |
| b_in | input | N | Second unsigned operand |
| prod_out | output | 2N | Unsigned product, 2N bits |

## Verification
The bench goes after carries that cross a boundary. If the lower-word carry is dropped, all-ones operands lose 2^N from the product. If the middle sum is truncated to N bits, operand pairs whose cross products overflow come out short by 2^(3N/2). If the zero extension of the upper slice is wrong, or the split is off by one bit, the worked 4-bit example and the exhaustive 4-bit and 8-bit sweeps fail. Zero, unit and commuted operands show a leaf or half that is wired to the wrong input. Sampling just before and just after an edge shows a register that loads early or late.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
   // width at which the recursion stops and the product is formed from gates
   localparam int LEAF_W = 2;

   function automatic bit width_ok(input int w);
      return (w >= LEAF_W) && ((w & (w - 1)) == 0);
   endfunction
endpackage

// File: rtl/hsm_leaf_mul.sv
// 2x2 unsigned product from gates
module hsm_leaf_mul (
   input  logic [1:0] x,
   input  logic [1:0] y,
   output logic [3:0] p
);
   logic pp10, pp01, pp11, c1;

   always_comb begin
      pp10 = x[1] & y[0];
      pp01 = x[0] & y[1];
      pp11 = x[1] & y[1];
      c1   = pp10 & pp01;
      p[0] = x[0] & y[0];
      p[1] = pp10 ^ pp01;
      p[2] = pp11 ^ c1;
      p[3] = pp11 & c1;
   end
endmodule

// File: rtl/hsm_merge.sv
// Merges four W-bit sub-products of W/2-bit halves into one 2W-bit product
module hsm_merge #(
   parameter int W = 4
) (
   input  logic [W-1:0]   p_ll,
   input  logic [W-1:0]   p_lh,
   input  logic [W-1:0]   p_hl,
   input  logic [W-1:0]   p_hh,
   output logic [2*W-1:0] p
);
   localparam int HW = W / 2;
   localparam int SW = W + 1 + HW;   // width of shifted middle term

   logic [W:0]    mid_sum;
   logic [SW-1:0] mid_shift;
   logic [W-1:0]  mid_lo;
   logic [W-1:0]  mid_hi;
   logic [W:0]    lo_sum;
   logic [W-1:0]  hi_sum;

   always_comb begin
      mid_sum   = {1'b0, p_lh} + {1'b0, p_hl};
      mid_shift = {mid_sum, {HW{1'b0}}};
      mid_lo    = mid_shift[W-1:0];
      mid_hi    = {{(W - (SW - W)){1'b0}}, mid_shift[SW-1:W]};
      lo_sum    = {1'b0, p_ll} + {1'b0, mid_lo};
      hi_sum    = p_hh + mid_hi + {{(W-1){1'b0}}, lo_sum[W]};
      p         = {hi_sum, lo_sum[W-1:0]};
   end
endmodule

// File: rtl/hsm_core.sv
// Recursive combinational multiplier core
module hsm_core #(
   parameter int W = 4
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [2*W-1:0] p
);
   localparam int HW = W / 2;

   generate
      if (W == hsm_pkg::LEAF_W) begin : g_leaf
         hsm_leaf_mul u_leaf (.x(x), .y(y), .p(p));
      end else begin : g_split
         logic [W-1:0] s_ll, s_lh, s_hl, s_hh;

         hsm_core #(.W(HW)) u_ll (.x(x[HW-1:0]), .y(y[HW-1:0]), .p(s_ll));
         hsm_core #(.W(HW)) u_lh (.x(x[HW-1:0]), .y(y[W-1:HW]), .p(s_lh));
         hsm_core #(.W(HW)) u_hl (.x(x[W-1:HW]), .y(y[HW-1:0]), .p(s_hl));
         hsm_core #(.W(HW)) u_hh (.x(x[W-1:HW]), .y(y[W-1:HW]), .p(s_hh));

         hsm_merge #(.W(W)) u_merge (
            .p_ll(s_ll), .p_lh(s_lh), .p_hl(s_hl), .p_hh(s_hh), .p(p)
         );
      end
   endgenerate
endmodule

// File: rtl/hsm_mul.sv
module hsm_mul #(
   parameter int N       = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   a_in,
   input  logic [N-1:0]   b_in,
   output logic [2*N-1:0] prod_out
);
   localparam int PW = 2 * N;

   // R7: legal widths only
   generate
      if (!hsm_pkg::width_ok(N)) begin : g_bad_width
         $error("hsm_mul: N must be a power of two and at least 2");
      end
   endgenerate

   logic [PW-1:0] prod_c;

   hsm_core #(.W(N)) u_core (.x(a_in), .y(b_in), .p(prod_c));

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_out <= '0;
            else        prod_out <= prod_c;
         end
      end else begin : g_comb
         assign prod_out = prod_c;
      end
   endgenerate
endmodule

// File: rtl/hsm_mul_chk.sv
module hsm_mul_chk #(
   parameter int N       = 16,
   parameter bit OUT_REG = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [N-1:0]   a_in,
   input logic [N-1:0]   b_in,
   input logic [2*N-1:0] prod_out
);
   localparam int PW = 2 * N;

   generate
      if (OUT_REG) begin : g_reg_chk
         logic [PW-1:0] ref_q;
         logic [N-1:0]  a_q, b_q;
         logic          live_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ref_q  <= '0;
               a_q    <= '0;
               b_q    <= '0;
               live_q <= 1'b0;
            end else begin
               ref_q  <= PW'(a_in) * PW'(b_in);
               a_q    <= a_in;
               b_q    <= b_in;
               live_q <= 1'b1;
            end
         end

         AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> prod_out == ref_q);  // R1
         AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && (a_q == '0 || b_q == '0)) |-> prod_out == '0);  // R2
         AST_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> prod_out[0] == (a_q[0] & b_q[0]));  // R5
         AST_UNIT_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && b_q == N'(1)) |-> prod_out == PW'(a_q));  // R9
         AST_RESET_CLEAR: assert property (@(posedge clk)
            !rst_n |-> prod_out == '0);  // R6
      end else begin : g_comb_chk
         AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
            prod_out == PW'(a_in) * PW'(b_in));  // R1
         AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
            (a_in == '0 || b_in == '0) |-> prod_out == '0);  // R2
         AST_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            prod_out[0] == (a_in[0] & b_in[0]));  // R5
         AST_UNIT_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
            (b_in == N'(1)) |-> prod_out == PW'(a_in));  // R9
      end
   endgenerate
endmodule

bind hsm_mul hsm_mul_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/hsm_mul_test.sv
`timescale 1ns/1ps
module hsm_mul_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [3:0]  a4,  b4;   logic [7:0]  p4;
   logic [7:0]  a8,  b8;   logic [15:0] p8;
   logic [15:0] a16, b16;  logic [31:0] p16;
   logic [31:0] a32, b32;  logic [63:0] p32;

   hsm_mul #(.N(4))  u4   (.clk(clk), .rst_n(rst_n), .a_in(a4),  .b_in(b4),  .prod_out(p4));
   hsm_mul #(.N(8))  u8   (.clk(clk), .rst_n(rst_n), .a_in(a8),  .b_in(b8),  .prod_out(p8));
   hsm_mul #(.N(16)) uut  (.clk(clk), .rst_n(rst_n), .a_in(a16), .b_in(b16), .prod_out(p16));
   hsm_mul #(.N(32)) u32  (.clk(clk), .rst_n(rst_n), .a_in(a32), .b_in(b32), .prod_out(p32));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] mul64(input logic [31:0] x, input logic [31:0] y);
      return {32'b0, x} * {32'b0, y};
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   // R6: output cleared while reset is low
   task automatic t_reset();
      a4 = '1; b4 = '1; a8 = '1; b8 = '1;
      a16 = '1; b16 = '1; a32 = '1; b32 = '1;
      step(); step();
      chk("R6 reset n4",  64'(p4),  64'h0);
      chk("R6 reset n8",  64'(p8),  64'h0);
      chk("R6 reset n16", 64'(p16), 64'h0);
      chk("R6 reset n32", p32,      64'h0);
      rst_n = 1'b1;
      step();
   endtask

   // R7: each legal width builds with a 2N-bit product
   task automatic t_widths();
      chk("R7 width n4",  64'($bits(p4)),  64'd8);
      chk("R7 width n8",  64'($bits(p8)),  64'd16);
      chk("R7 width n16", 64'($bits(p16)), 64'd32);
      chk("R7 width n32", 64'($bits(p32)), 64'd64);
   endtask

   // R8: worked 4-bit example
   task automatic t_example();
      a4 = 4'b0011; b4 = 4'b1001;
      step();
      chk("R8 low word",  64'(p4[3:0]), 64'b1011);
      chk("R8 high word", 64'(p4[7:4]), 64'b0001);
      chk("R8 product",   64'(p4),      64'b00011011);
   endtask

   // R1 / R5: exhaustive sweeps of the 4-bit and 8-bit instances
   task automatic t_sweep4();
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            a4 = 4'(i); b4 = 4'(j);
            step();
            chk("R1 sweep n4", 64'(p4), 64'(i * j));
            chk("R5 lsb n4", 64'(p4[0]), 64'(i[0] & j[0]));
         end
      end
   endtask

   task automatic t_sweep8();
      for (int i = 0; i < 256; i++) begin
         for (int j = 0; j < 256; j++) begin
            a8 = 8'(i); b8 = 8'(j);
            step();
            chk("R1 sweep n8", 64'(p8), 64'(i * j));
         end
      end
   endtask

   // R2 R3 R4 R9: corner operands on the 16-bit and 32-bit instances
   task automatic t_corners();
      a16 = 16'h0; b16 = 16'hBEEF; a32 = 32'hDEAD_BEEF; b32 = 32'h0;
      step();
      chk("R2 zero a n16", 64'(p16), 64'h0);
      chk("R2 zero b n32", p32,      64'h0);
      a16 = 16'h0; b16 = 16'h0; a32 = 32'h0; b32 = 32'h0;
      step();
      chk("R2 both zero n16", 64'(p16), 64'h0);
      chk("R2 both zero n32", p32,      64'h0);
      a16 = '1; b16 = '1; a32 = '1; b32 = '1;
      step();
      chk("R3 all ones n16", 64'(p16), 64'hFFFE_0001);
      chk("R3 all ones n32", p32,      64'hFFFF_FFFE_0000_0001);
      a16 = 16'h00FF; b16 = 16'hFF01; a32 = 32'h0000_FFFF; b32 = 32'hFFFF_FFFF;
      step();
      chk("R4 low carry n16", 64'(p16), mul64(32'h00FF, 32'hFF01));
      chk("R4 low carry n32", p32,      mul64(32'h0000_FFFF, 32'hFFFF_FFFF));
      a16 = 16'hFFFF; b16 = 16'h8001; a32 = 32'h8000_0001; b32 = 32'hFFFF_0001;
      step();
      chk("R4 mid carry n16", 64'(p16), mul64(32'hFFFF, 32'h8001));
      chk("R4 mid carry n32", p32,      mul64(32'h8000_0001, 32'hFFFF_0001));
      a16 = 16'hA5C3; b16 = 16'h0001; a32 = 32'h0000_0001; b32 = 32'hF00D_CAFE;
      step();
      chk("R9 unit n16", 64'(p16), 64'hA5C3);
      chk("R9 unit n32", p32,      64'hF00D_CAFE);
   endtask

   // R6: product loads at the edge, not before
   task automatic t_latency();
      a16 = 16'd2; b16 = 16'd3;
      step();
      chk("R6 first result", 64'(p16), 64'd6);
      a16 = 16'd5; b16 = 16'd7;
      #1.5;
      chk("R6 holds before edge", 64'(p16), 64'd6);
      step();
      chk("R6 loads after edge", 64'(p16), 64'd35);
   endtask

   // R1: random operands at 16 and 32 bits
   task automatic t_random();
      for (int k = 0; k < 600; k++) begin
         a16 = 16'($urandom); b16 = 16'($urandom);
         a32 = $urandom; b32 = $urandom;
         step();
         chk("R1 random n16", 64'(p16), mul64(32'(a16), 32'(b16)));
         chk("R1 random n32", p32, mul64(a32, b32));
      end
   endtask

   // R10: swapped operands
   task automatic t_commute();
      for (int k = 0; k < 100; k++) begin
         logic [31:0] x = $urandom;
         logic [31:0] y = $urandom;
         logic [63:0] first;
         a32 = x; b32 = y;
         step();
         first = p32;
         a32 = y; b32 = x;
         step();
         chk("R10 swap n32", p32, first);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_widths();
      t_example();
      t_sweep4();
      t_corners();
      t_latency();
      t_random();
      t_commute();
      t_sweep8();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule